// File: doc/BRIEF.md
# Converter-Clocked Serial Frame Receiver

This block is the host side of a link to a delta-sigma converter that produces its own serial clock. The block runs on a fast system clock. It brings the converter's clock line and data line into its own domain through two-flop synchronisers and finds the clock edges by comparing each sample with the one before. While the converter is converting, its clock line stays high. When the clock line and the data line are both low, the conversion has ended and a transfer is due.

During each transfer the block shifts in a 32-bit result word on the rising clock edges. On the same edges the converter samples the block's serial output, which carries an 8-bit channel-select word. The host changes that output only after a falling edge, so each bit is settled before the next rising edge. Once the last bit has arrived, the block presents the word with a one-cycle strobe, the decoded fields and a parity verdict. A new channel setting can be written at any time and takes effect at the next transfer. A watchdog abandons a transfer if the converter's clock stops partway through.

The system clock must run at least 8 times faster than the converter's serial clock.

Top module: `adc_frame_rx`

## Requirements
- R1: After reset, `frame_valid`, `timeout_err` and `sdi_o` are all 0 and no transfer is in progress.
- R2: A transfer starts only when the synchronised clock line and data line are both low after the clock line has been seen high. Before the first rising edge, `sdi_o` already carries the first configuration bit, which is 1.
- R3: On rising edges 1 to 8 of a transfer, `sdi_o` carries 1, 0, enable, single-ended select, odd/sign select, address bit 2, address bit 1, address bit 0, in that order. On rising edges 9 to 32 it carries 0. It changes only after a detected falling edge.
- R4: The data line is sampled on each of the 32 rising edges, first bit into bit 31. A 32-bit result word is the 32 bits sampled on the rising edges of one transfer. Within a few system clocks after the 32nd rising edge, `frame_valid` pulses for one cycle, and `frame_data` then holds that result word.
- R5: `eoc_bit` is `frame_data[31]`, `sign_bit` is `frame_data[29]`, and `result` is `frame_data[28:6]`, with bit 28 as its MSB. Bits 5 to 1 drive no output field.
- R6: `parity_err` is 1 together with `frame_valid` exactly when the XOR of all 32 received bits is 1, that is, when even parity over bits 31..1 differs from bit 0.
- R7: A configuration written with `cfg_wr` while a transfer is running does not alter that transfer's SDI bits. It is sent in the next transfer.
- R8: If no clock edge is seen for `timeout_lim` system clocks during a transfer, `timeout_err` pulses for one cycle and no `frame_valid` follows. The block re-arms only after the clock line has been seen high again.
- R9: `srst` high on a clock edge abandons any transfer and clears `sdi_o` to 0 without a `frame_valid`. Normal transfers resume afterwards.
- R10: A low data line while the clock line stays high does not start a transfer, so `sdi_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| srst | input | 1 | Synchronous abort back to waiting |
| sck_i | input | 1 | Serial clock from the converter |
| sdo_i | input | 1 | Serial data from the converter |
| sdi_o | output | 1 | Serial configuration data to the converter |
| cfg_wr | input | 1 | Write strobe for the pending channel setting |
| cfg_en | input | 1 | Enable bit of the setting |
| cfg_sgl | input | 1 | Single-ended/differential select |
| cfg_odd | input | 1 | Odd/sign select |
| cfg_addr | input | 3 | Channel address |
| timeout_lim | input | TO_W | Idle system clocks allowed between edges during a transfer |
| frame_valid | output | 1 | One-cycle strobe: a new word is in frame_data |
| frame_data | output | 32 | Last received word |
| eoc_bit | output | 1 | End-of-conversion bit of the word |
| sign_bit | output | 1 | Sign indicator of the word |
| result | output | 23 | Conversion result field |
| parity_err | output | 1 | Parity mismatch, valid with frame_valid |
| timeout_err | output | 1 | One-cycle strobe: transfer abandoned for lack of clock edges |

## Verification
The hardest situations to reach are the ones where the converter misbehaves partway through a transfer. One is a clock that stops after some edges, either high or stuck low with the data line low, which looks like a new end of conversion. Another is a reset or configuration write that lands in the middle of a transfer. A bench model of the converter can stop after any chosen number of rising edges and park the lines in any state. Forked threads place configuration writes and aborts at fixed cycle offsets inside a running transfer. Random result words with random parity bits and random settings cover the normal path around these directed cases.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;
  localparam int FRAME_W  = 32;
  localparam int CFG_W    = 8;
  localparam int CNT_W    = $clog2(FRAME_W + 1);
  localparam int EOC_POS  = 31;
  localparam int SIGN_POS = 29;
  localparam int MSB_POS  = 28;
  localparam int LSB_POS  = 6;
  localparam int RES_W    = MSB_POS - LSB_POS + 1;

  typedef enum logic [1:0] {
    ST_BUSY = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic       en;
    logic       sgl;
    logic       odd;
    logic [2:0] addr;
  } chan_cfg_t;

  function automatic logic [CFG_W-1:0] cfg_word(input chan_cfg_t c);
    return {2'b10, c.en, c.sgl, c.odd, c.addr};
  endfunction
endpackage

// File: rtl/adc_line_sync.sv
module adc_line_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/adc_cfg_stage.sv
module adc_cfg_stage
  import adc_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  chan_cfg_t        cfg_in,
  output logic [CFG_W-1:0] word_o
);
  chan_cfg_t pend_q, pend_n;

  always_comb begin
    pend_n = pend_q;
    if (wr) pend_n = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_n;
  end

  assign word_o = cfg_word(pend_q);

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(word_o));
endmodule

// File: rtl/adc_frame_engine.sv
module adc_frame_engine
  import adc_rx_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               srst,
  input  logic               sck_s,
  input  logic               sdo_s,
  input  logic [CFG_W-1:0]   cfg_word_i,
  input  logic [TO_W-1:0]    lim,
  output logic               sdi_o,
  output logic               valid_o,
  output logic [FRAME_W-1:0] data_o,
  output logic               perr_o,
  output logic               tout_o
);
  rx_state_e          state_q, state_n;
  logic [CNT_W-1:0]   bit_q, bit_n;
  logic [FRAME_W-1:0] rx_q, rx_n, data_n;
  logic [CFG_W-1:0]   tx_q, tx_n;
  logic [TO_W-1:0]    idle_q, idle_n;
  logic               sck_d_q;
  logic               valid_n, perr_n, tout_n;
  logic               rise, fall;
  logic [FRAME_W-1:0] rx_shift;

  assign rise     = sck_s & ~sck_d_q;
  assign fall     = ~sck_s & sck_d_q;
  assign rx_shift = {rx_q[FRAME_W-2:0], sdo_s};

  always_comb begin
    state_n = state_q;
    bit_n   = bit_q;
    rx_n    = rx_q;
    tx_n    = tx_q;
    idle_n  = '0;
    data_n  = data_o;
    valid_n = 1'b0;
    perr_n  = 1'b0;
    tout_n  = 1'b0;
    unique case (state_q)
      ST_BUSY: begin
        if (sck_s) state_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (!sck_s && !sdo_s) begin
          state_n = ST_XFER;
          tx_n    = cfg_word_i;
          bit_n   = '0;
        end
      end
      ST_XFER: begin
        if (rise) begin
          rx_n  = rx_shift;
          bit_n = bit_q + 1'b1;
          if (bit_q == CNT_W'(FRAME_W - 1)) begin
            state_n = ST_BUSY;
            valid_n = 1'b1;
            data_n  = rx_shift;
            perr_n  = ^rx_shift;
            tx_n    = '0;
          end
        end else if (fall) begin
          tx_n = {tx_q[CFG_W-2:0], 1'b0};
        end else if (idle_q >= lim) begin
          tout_n  = 1'b1;
          state_n = ST_BUSY;
          tx_n    = '0;
        end else begin
          idle_n = idle_q + 1'b1;
        end
      end
      default: state_n = ST_BUSY;
    endcase
    if (srst) begin
      state_n = ST_BUSY;
      tx_n    = '0;
      bit_n   = '0;
      valid_n = 1'b0;
      perr_n  = 1'b0;
      tout_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BUSY;
      bit_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      idle_q  <= '0;
      sck_d_q <= 1'b1;
      data_o  <= '0;
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      tout_o  <= 1'b0;
    end else begin
      state_q <= state_n;
      bit_q   <= bit_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
      idle_q  <= idle_n;
      sck_d_q <= sck_s;
      data_o  <= data_n;
      valid_o <= valid_n;
      perr_o  <= perr_n;
      tout_o  <= tout_n;
    end
  end

  assign sdi_o = tx_q[CFG_W-1];

  // R8
  tout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tout_o |-> !valid_o);
  // R3
  sdi_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER && $past(state_q) == ST_XFER && !$stable(sdi_o)) |-> $past(fall));
  // R4
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_XFER |-> bit_q < CNT_W'(FRAME_W));
  // R10
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER && $past(state_q) != ST_XFER) |-> ($past(!sck_s) && $past(!sdo_s)));
  // R2
  idle_sdi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != ST_XFER |-> !sdi_o);
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx
  import adc_rx_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               srst,
  input  logic               sck_i,
  input  logic               sdo_i,
  output logic               sdi_o,
  input  logic               cfg_wr,
  input  logic               cfg_en,
  input  logic               cfg_sgl,
  input  logic               cfg_odd,
  input  logic [2:0]         cfg_addr,
  input  logic [TO_W-1:0]    timeout_lim,
  output logic               frame_valid,
  output logic [FRAME_W-1:0] frame_data,
  output logic               eoc_bit,
  output logic               sign_bit,
  output logic [RES_W-1:0]   result,
  output logic               parity_err,
  output logic               timeout_err
);
  logic [1:0]       rst_pipe_q;
  logic             rst_s_n;
  logic [1:0]       lines_s;
  logic [CFG_W-1:0] cfg_w;
  chan_cfg_t        cfg_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  adc_line_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .din   ({sck_i, sdo_i}),
    .dout  (lines_s)
  );

  assign cfg_in = '{en: cfg_en, sgl: cfg_sgl, odd: cfg_odd, addr: cfg_addr};

  adc_cfg_stage u_cfg (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wr     (cfg_wr),
    .cfg_in (cfg_in),
    .word_o (cfg_w)
  );

  adc_frame_engine #(.TO_W(TO_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .srst       (srst),
    .sck_s      (lines_s[1]),
    .sdo_s      (lines_s[0]),
    .cfg_word_i (cfg_w),
    .lim        (timeout_lim),
    .sdi_o      (sdi_o),
    .valid_o    (frame_valid),
    .data_o     (frame_data),
    .perr_o     (parity_err),
    .tout_o     (timeout_err)
  );

  assign eoc_bit  = frame_data[EOC_POS];
  assign sign_bit = frame_data[SIGN_POS];
  assign result   = frame_data[MSB_POS:LSB_POS];
endmodule

// File: tb/tb_adc_frame_rx.sv
`timescale 1ns/1ps
module tb_adc_frame_rx;
  import adc_rx_pkg::*;
  localparam int TO_W = 16;
  localparam int H    = 8;
  localparam int LIM  = 100;

  logic clk = 1'b0;
  logic rst_n, srst, sck, sdo, sdi_o, cfg_wr, cfg_en, cfg_sgl, cfg_odd;
  logic [2:0] cfg_addr;
  logic [TO_W-1:0] timeout_lim;
  logic frame_valid, eoc_bit, sign_bit, parity_err, timeout_err;
  logic [31:0] frame_data;
  logic [RES_W-1:0] result;

  int tests = 0, fails = 0, vcount = 0, tcount = 0;
  logic [31:0] last_data;
  logic last_perr, last_eoc, last_sign;
  logic [RES_W-1:0] last_res;
  logic [7:0] got_a, got_b;

  always #2.5 clk = ~clk;

  adc_frame_rx #(.TO_W(TO_W)) dut (
    .clk(clk), .rst_n(rst_n), .srst(srst), .sck_i(sck), .sdo_i(sdo), .sdi_o(sdi_o),
    .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_sgl(cfg_sgl), .cfg_odd(cfg_odd),
    .cfg_addr(cfg_addr), .timeout_lim(timeout_lim), .frame_valid(frame_valid),
    .frame_data(frame_data), .eoc_bit(eoc_bit), .sign_bit(sign_bit), .result(result),
    .parity_err(parity_err), .timeout_err(timeout_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_valid) begin
        vcount++;
        last_data = frame_data; last_perr = parity_err;
        last_eoc = eoc_bit; last_sign = sign_bit; last_res = result;
      end
      if (timeout_err) tcount++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_cfg(input logic en, sgl, odd, input logic [2:0] a);
    return {2'b10, en, sgl, odd, a};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic en, sgl, odd, input logic [2:0] a);
    @(negedge clk);
    cfg_en = en; cfg_sgl = sgl; cfg_odd = odd; cfg_addr = a; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Converter model: end of conversion, then nrise rising edges
  task automatic conv_frame(input logic [31:0] d, input int nrise, output logic [7:0] got);
    got = '0;
    @(negedge clk);
    sdo = 1'b0; sck = 1'b0;
    wait_n(H);
    for (int i = 0; i < nrise; i++) begin
      if (i < 8) got[7-i] = sdi_o;
      else if (sdi_o !== 1'b0) check(0, "R3", "sdi after bit 8", {31'd0, sdi_o}, 32'd0);
      sck = 1'b1;
      wait_n(H);
      if (i == 31) sdo = 1'b1;
      else if (i < nrise - 1) begin
        sck = 1'b0; sdo = d[30-i];
        wait_n(H);
      end
    end
  endtask

  task automatic check_frame(input logic [31:0] d, input int v0, input logic [7:0] got,
                             input logic [7:0] expc);
    wait_n(10);
    check(vcount == v0 + 1, "R4", "valid pulse count", vcount, v0 + 1);
    check(last_data == d, "R4", "frame_data", last_data, d);
    check(last_perr == ^d, "R6", "parity_err", {31'd0, last_perr}, {31'd0, ^d});
    check(last_eoc == d[31] && last_sign == d[29], "R5", "eoc/sign",
          {30'd0, last_eoc, last_sign}, {30'd0, d[31], d[29]});
    check(last_res == d[28:6], "R5", "result field", {9'd0, last_res}, {9'd0, d[28:6]});
    check(got == expc, "R3", "sdi config word", {24'd0, got}, {24'd0, expc});
    check(sdi_o == 1'b0, "R2", "sdi idle after frame", {31'd0, sdi_o}, 32'd0);
    wait_n(20);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    logic [7:0] got;
    int v0, t0;
    logic en, sgl, odd;
    logic [2:0] a;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; srst = 1'b0; sck = 1'b1; sdo = 1'b1;
    cfg_wr = 1'b0; cfg_en = 1'b0; cfg_sgl = 1'b0; cfg_odd = 1'b0; cfg_addr = 3'd0;
    timeout_lim = TO_W'(LIM);
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    // R1 reset state
    check(frame_valid == 0 && timeout_err == 0 && sdi_o == 0, "R1", "reset outputs",
          {29'd0, frame_valid, timeout_err, sdi_o}, 32'd0);

    // R2 R3 R4 directed frame, correct parity
    write_cfg(1, 0, 1, 3'd5);
    d = 32'h1ABC_DE40; d[31] = 1'b0; d[0] = ^d[31:1];
    v0 = vcount;
    conv_frame(d, 32, got);
    check_frame(d, v0, got, exp_cfg(1, 0, 1, 3'd5));

    // R6 directed parity error, bits 5..1 set
    d = 32'h2000_003E; d[0] = ~(^d[31:1]);
    v0 = vcount;
    conv_frame(d, 32, got);
    check_frame(d, v0, got, exp_cfg(1, 0, 1, 3'd5));

    // R10 low data with high clock does not start a transfer
    v0 = vcount;
    @(negedge clk); sdo = 1'b0;
    wait_n(60);
    check(sdi_o == 1'b0 && vcount == v0, "R10", "no start while sck high",
          {31'd0, sdi_o}, 32'd0);
    sdo = 1'b1;
    wait_n(10);

    // R7 configuration write during a frame
    write_cfg(0, 1, 0, 3'd2);
    d = $urandom; d[31] = 1'b0;
    v0 = vcount;
    fork
      conv_frame(d, 32, got_a);
      begin wait_n(100); write_cfg(1, 1, 1, 3'd7); end
    join
    check_frame(d, v0, got_a, exp_cfg(0, 1, 0, 3'd2));
    d = $urandom; d[31] = 1'b0;
    v0 = vcount;
    conv_frame(d, 32, got_b);
    check(got_b == exp_cfg(1, 1, 1, 3'd7), "R7", "held config used next",
          {24'd0, got_b}, {24'd0, exp_cfg(1, 1, 1, 3'd7)});
    check_frame(d, v0, got_b, exp_cfg(1, 1, 1, 3'd7));

    // R8 timeout with clock parked high
    v0 = vcount; t0 = tcount;
    conv_frame(32'h0, 10, got);
    wait_n(LIM + 40);
    check(tcount == t0 + 1, "R8", "timeout pulse, sck high", tcount, t0 + 1);
    check(vcount == v0, "R8", "no valid after timeout", vcount, v0);
    @(negedge clk); sdo = 1'b1;
    wait_n(10);

    // R8 timeout with clock stuck low and data low: no re-arm
    v0 = vcount; t0 = tcount;
    conv_frame(32'h0, 5, got);
    @(negedge clk); sck = 1'b0; sdo = 1'b0;
    wait_n(LIM + 40);
    check(tcount == t0 + 1, "R8", "timeout pulse, sck low", tcount, t0 + 1);
    wait_n(100);
    check(sdi_o == 1'b0 && tcount == t0 + 1 && vcount == v0, "R8", "no restart while stuck",
          {31'd0, sdi_o}, 32'd0);
    @(negedge clk); sck = 1'b1; sdo = 1'b1;
    wait_n(20);

    // R9 synchronous abort mid-frame
    v0 = vcount; t0 = tcount;
    conv_frame(32'h0, 3, got);
    @(negedge clk); sdo = 1'b1; srst = 1'b1;
    @(negedge clk); srst = 1'b0;
    wait_n(LIM + 40);
    check(vcount == v0 && tcount == t0 && sdi_o == 1'b0, "R9", "srst abandons frame",
          {vcount - v0, tcount - t0, sdi_o}, 32'd0);
    d = 32'h0FFF_FFC1;
    v0 = vcount;
    conv_frame(d, 32, got);
    check_frame(d, v0, got, exp_cfg(1, 1, 1, 3'd7));

    // Random frames and settings
    for (int k = 0; k < 20; k++) begin
      en = 1'($urandom); sgl = 1'($urandom); odd = 1'($urandom); a = 3'($urandom);
      write_cfg(en, sgl, odd, a);
      d2 = $urandom; d2[31] = 1'b0;
      v0 = vcount;
      conv_frame(d2, 32, got);
      check_frame(d2, v0, got, exp_cfg(en, sgl, odd, a));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule